// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central issue controller of a small out-of-order machine with eight architectural registers and four execution units: integer (unit 0), multiply (unit 1), add (unit 2) and divide (unit 3). Each cycle it is offered one decoded instruction. The instruction carries the class of unit it needs, a destination register and two source registers, and is transferred with a valid/ready handshake. Once accepted, the instruction is tracked in a per-unit status entry. That entry holds the busy flag, the destination, both sources, the producing unit of each source and a ready flag per source. A per-register table records which unit will write each register.

The controller moves every instruction through four steps: issue, operand read, execution done and result write. It grants operand reads as soon as both sources are available in the register file, so instructions can enter execution out of program order. It holds a finished result back while an earlier instruction still has to read the old value of the destination register. The execution units are outside the block. They latch the instruction at acceptance, read the register file when given a read grant, pulse a done line after their own latency, and write the register file when given a write grant. There is no forwarding path, so a consumer always reads a produced value from the register file after the producer has written it.

Top module: `scoreboard_ctrl`

## Requirements
- R1: The offered instruction is accepted only if its unit (class encoding: 0 integer, 1 multiply, 2 add, 3 divide) is not busy. While the unit is busy, `inReady` stays low and the instruction waits at the input, so later instructions cannot pass it.
- R2: The offered instruction is accepted only if no in-flight instruction has the same destination register. After the pending writer's write grant, the instruction is accepted in the following cycle.
- R3: After synchronous reset every unit is idle and no register has a pending writer. `inReady` is high for any offered instruction, and no read or write grant is given.
- R4: `readGrant[u]` is high for exactly one cycle per instruction: in the first cycle in which unit u is busy, has not yet read, and both of its sources are ready. A source is ready at acceptance when no pending writer targets it, or when that writer receives its write grant in the acceptance cycle.
- R5: A source that waits on a producer becomes ready once that producer is granted its write. The consumer's read grant can come in the very next cycle.
- R6: A `doneIn[u]` pulse counts only if unit u is busy and its read grant was given in an earlier cycle. Any other pulse is ignored and leads to no write grant.
- R7: A finished unit is not granted its write while another unit still has a ready but unread source that equals its destination register. The grant follows in the cycle after that reader's read grant.
- R8: At most one write grant is given per cycle, and the lowest-numbered eligible unit wins. `writeReg` shows the destination of the granted unit.
- R9: After its write grant, a unit and its destination register are free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Offered instruction is valid |
| inReady | output | 1 | Offered instruction can be accepted this cycle |
| inUnit | input | 2 | Unit class of the instruction |
| inDst | input | 3 | Destination register |
| inSrcA | input | 3 | First source register |
| inSrcB | input | 3 | Second source register |
| doneIn | input | 4 | Per-unit execution-done pulse |
| readGrant | output | 4 | Per-unit operand-read grant |
| writeGrant | output | 4 | Per-unit result-write grant, at most one high |
| writeReg | output | 3 | Destination register of the granted write |

## Verification
The bench builds the block with its default sizes: eight registers and four units. Random register numbers drawn from only eight values make chains of destination collisions and old-value readers common in every few instructions. Unit latencies drawn from one to six cycles let finishes coincide, which tests the write-grant priority. Directed sequences pin down the exact cycle relations between a producer's write, its consumer's read, and a write held back by an unread source.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int SB_REGS  = 8;
  parameter int SB_UNITS = 4;
  localparam int RW = $clog2(SB_REGS);
  localparam int UW = $clog2(SB_UNITS);

  typedef logic [RW-1:0] regIdx_t;
  typedef logic [UW-1:0] unitIdx_t;

  // Per-unit status entry
  typedef struct packed {
    logic     busy;
    logic     readDone;
    logic     execDone;
    regIdx_t  fi;
    regIdx_t  fj;
    regIdx_t  fk;
    unitIdx_t qj;
    unitIdx_t qk;
    logic     qjPend;
    logic     qkPend;
    logic     rj;
    logic     rk;
  } unitStat_t;

  // Per-register pending writer
  typedef struct packed {
    logic     pend;
    unitIdx_t unit;
  } regProd_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic                issueEn;
    unitIdx_t            issueUnit;
    logic [SB_UNITS-1:0] readEn;
    logic [SB_UNITS-1:0] writeEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/sb_tables.sv
module sb_tables
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  regIdx_t             inDst,
  input  regIdx_t             inSrcA,
  input  regIdx_t             inSrcB,
  input  logic [SB_UNITS-1:0] doneIn,
  output unitStat_t           unitStat [SB_UNITS],
  output regProd_t            regProd  [SB_REGS]
);
  unitIdx_t wrIdx;
  logic     wrAny;
  logic     srcAPend;
  logic     srcBPend;

  always_comb begin
    wrAny = |strobe.writeEn;
    wrIdx = '0;
    for (int u = 0; u < SB_UNITS; u++) begin
      if (strobe.writeEn[u]) wrIdx = unitIdx_t'(u);
    end
  end

  // A producer writing in the acceptance cycle no longer blocks the source
  always_comb begin
    srcAPend = regProd[inSrcA].pend && !(wrAny && regProd[inSrcA].unit == wrIdx);
    srcBPend = regProd[inSrcB].pend && !(wrAny && regProd[inSrcB].unit == wrIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < SB_UNITS; u++) unitStat[u] <= '0;
      for (int r = 0; r < SB_REGS; r++) regProd[r] <= '0;
    end else begin
      for (int u = 0; u < SB_UNITS; u++) begin
        if (doneIn[u] && unitStat[u].busy && unitStat[u].readDone && !strobe.writeEn[u])
          unitStat[u].execDone <= 1'b1;
        if (strobe.writeEn[u]) begin
          unitStat[u].busy     <= 1'b0;
          unitStat[u].execDone <= 1'b0;
          regProd[unitStat[u].fi].pend <= 1'b0;
        end
        if (wrAny && unitStat[u].qjPend && unitStat[u].qj == wrIdx) begin
          unitStat[u].qjPend <= 1'b0;
          unitStat[u].rj     <= 1'b1;
        end
        if (wrAny && unitStat[u].qkPend && unitStat[u].qk == wrIdx) begin
          unitStat[u].qkPend <= 1'b0;
          unitStat[u].rk     <= 1'b1;
        end
        if (strobe.readEn[u]) begin
          unitStat[u].readDone <= 1'b1;
          unitStat[u].rj       <= 1'b0;
          unitStat[u].rk       <= 1'b0;
        end
      end
      if (strobe.issueEn) begin
        unitStat[strobe.issueUnit] <= '{busy: 1'b1, readDone: 1'b0, execDone: 1'b0,
                                        fi: inDst, fj: inSrcA, fk: inSrcB,
                                        qj: regProd[inSrcA].unit, qk: regProd[inSrcB].unit,
                                        qjPend: srcAPend, qkPend: srcBPend,
                                        rj: !srcAPend, rk: !srcBPend};
        regProd[inDst] <= '{pend: 1'b1, unit: strobe.issueUnit};
      end
    end
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  unitStat_t           unitStat [SB_UNITS],
  input  regProd_t            regProd  [SB_REGS],
  input  logic                inValid,
  input  unitIdx_t            inUnit,
  input  regIdx_t             inDst,
  output logic                inReady,
  output ctrlStrobe_t         strobe,
  output logic [SB_UNITS-1:0] readGrant,
  output logic [SB_UNITS-1:0] writeGrant,
  output regIdx_t             writeReg
);
  logic [SB_UNITS-1:0] warBlock;
  logic [SB_UNITS-1:0] writeCand;
  logic                found;

  // Structural and WAW checks gate acceptance
  assign inReady = !unitStat[inUnit].busy && !regProd[inDst].pend;

  for (genvar g = 0; g < SB_UNITS; g++) begin : gUnit
    assign readGrant[g] = unitStat[g].busy && !unitStat[g].readDone &&
                          unitStat[g].rj && unitStat[g].rk;

    // WAR: another unit still holds an unread, ready copy of our destination
    always_comb begin
      warBlock[g] = 1'b0;
      for (int v = 0; v < SB_UNITS; v++) begin
        if (v != g && unitStat[v].busy &&
            ((unitStat[v].rj && unitStat[v].fj == unitStat[g].fi) ||
             (unitStat[v].rk && unitStat[v].fk == unitStat[g].fi)))
          warBlock[g] = 1'b1;
      end
    end

    assign writeCand[g] = unitStat[g].busy && unitStat[g].execDone && !warBlock[g];
  end

  // Fixed priority, lowest unit first
  always_comb begin
    found      = 1'b0;
    writeGrant = '0;
    writeReg   = '0;
    for (int u = 0; u < SB_UNITS; u++) begin
      if (writeCand[u] && !found) begin
        writeGrant[u] = 1'b1;
        writeReg      = unitStat[u].fi;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.issueEn   = inValid && inReady;
    strobe.issueUnit = inUnit;
    strobe.readEn    = readGrant;
    strobe.writeEn   = writeGrant;
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [UW-1:0]       inUnit,
  input  logic [RW-1:0]       inDst,
  input  logic [RW-1:0]       inSrcA,
  input  logic [RW-1:0]       inSrcB,
  input  logic [SB_UNITS-1:0] doneIn,
  output logic [SB_UNITS-1:0] readGrant,
  output logic [SB_UNITS-1:0] writeGrant,
  output logic [RW-1:0]       writeReg
);
  unitStat_t   unitStat [SB_UNITS];
  regProd_t    regProd  [SB_REGS];
  ctrlStrobe_t strobe;

  sb_ctrl u_ctrl (
    .unitStat   (unitStat),
    .regProd    (regProd),
    .inValid    (inValid),
    .inUnit     (inUnit),
    .inDst      (inDst),
    .inReady    (inReady),
    .strobe     (strobe),
    .readGrant  (readGrant),
    .writeGrant (writeGrant),
    .writeReg   (writeReg)
  );

  sb_tables u_tables (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inDst    (inDst),
    .inSrcA   (inSrcA),
    .inSrcB   (inSrcB),
    .doneIn   (doneIn),
    .unitStat (unitStat),
    .regProd  (regProd)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                inReady,
  input logic [UW-1:0]       inUnit,
  input logic [SB_UNITS-1:0] readGrant,
  input logic [SB_UNITS-1:0] writeGrant
);
  logic [SB_UNITS-1:0] busyShadow;
  logic [SB_UNITS-1:0] readShadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyShadow <= '0;
      readShadow <= '0;
    end else begin
      for (int u = 0; u < SB_UNITS; u++) begin
        if (inValid && inReady && inUnit == UW'(u)) busyShadow[u] <= 1'b1;
        if (readGrant[u]) readShadow[u] <= 1'b1;
        if (writeGrant[u]) begin
          busyShadow[u] <= 1'b0;
          readShadow[u] <= 1'b0;
        end
      end
    end
  end

  a_r1_issue_free_unit: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> !busyShadow[inUnit]);

  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (readGrant == '0 && writeGrant == '0));

  a_r4_read_only_busy: assert property (@(posedge clk) disable iff (rst)
    (readGrant & ~busyShadow) == '0);

  a_r4_read_once: assert property (@(posedge clk) disable iff (rst)
    (readGrant & readShadow) == '0);

  a_r6_write_after_read: assert property (@(posedge clk) disable iff (rst)
    (writeGrant & ~readShadow) == '0);

  a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(writeGrant));

  a_r9_no_repeat_write: assert property (@(posedge clk) disable iff (rst)
    (writeGrant != '0) |=> ((writeGrant & $past(writeGrant)) == '0));
endmodule

bind scoreboard_ctrl sb_checker u_sbChecker (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inReady    (inReady),
  .inUnit     (inUnit),
  .readGrant  (readGrant),
  .writeGrant (writeGrant)
);

// File: tb/tb_scoreboard_ctrl.sv
`timescale 1ns/1ps
module tb_scoreboard_ctrl;
  import sb_pkg::*;
  localparam int NU = SB_UNITS;
  localparam int NR = SB_REGS;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic          inValid;
  logic          inReady;
  logic [UW-1:0] inUnit;
  logic [RW-1:0] inDst, inSrcA, inSrcB;
  logic [NU-1:0] doneIn, readGrant, writeGrant;
  logic [RW-1:0] writeReg;

  scoreboard_ctrl dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inUnit(inUnit),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB), .doneIn(doneIn),
    .readGrant(readGrant), .writeGrant(writeGrant), .writeReg(writeReg)
  );

  int checks = 0;
  int errors = 0;
  int cycleNo = 0;

  // Reference model
  bit mBusy[NU], mRdDone[NU], mExDone[NU], mRj[NU], mRk[NU], mQjP[NU], mQkP[NU];
  int mFi[NU], mFj[NU], mFk[NU], mQj[NU], mQk[NU];
  bit pPend[NR];
  int pUnit[NR];
  int lat[NU], cnt[NU], lastRead[NU], lastWrite[NU];
  logic [NU-1:0] forceDone;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycleNo);
    end
  endtask

  function automatic bit expReadyF(input int u, input int d);
    return !mBusy[u] && !pPend[d];
  endfunction

  function automatic logic [NU-1:0] expReadF();
    logic [NU-1:0] r;
    for (int u = 0; u < NU; u++) r[u] = mBusy[u] && !mRdDone[u] && mRj[u] && mRk[u];
    return r;
  endfunction

  function automatic int expWinF();
    for (int u = 0; u < NU; u++) begin
      if (mBusy[u] && mExDone[u]) begin
        bit blocked = 1'b0;
        for (int v = 0; v < NU; v++)
          if (v != u && mBusy[v] && ((mRj[v] && mFj[v] == mFi[u]) || (mRk[v] && mFk[v] == mFi[u])))
            blocked = 1'b1;
        if (!blocked) return u;
      end
    end
    return -1;
  endfunction

  task automatic modelReset();
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mRdDone[u] = 0; mExDone[u] = 0; mRj[u] = 0; mRk[u] = 0;
      mQjP[u] = 0; mQkP[u] = 0; cnt[u] = 0; lastRead[u] = -1; lastWrite[u] = -1;
    end
    for (int r = 0; r < NR; r++) pPend[r] = 0;
  endtask

  task automatic tick(input bit v, input int un, input int d, input int a, input int b, output bit acc);
    logic [NU-1:0] eRd, eWv;
    int eW;
    bit eRdy;
    @(negedge clk);
    for (int u = 0; u < NU; u++) doneIn[u] = (cnt[u] == 1) || forceDone[u];
    inValid = v;
    inUnit = UW'(un);
    inDst = RW'(d);
    inSrcA = RW'(a);
    inSrcB = RW'(b);
    #1;
    eRdy = expReadyF(un, d);
    eRd = expReadF();
    eW = expWinF();
    eWv = '0;
    if (eW >= 0) eWv[eW] = 1'b1;
    check(inReady === eRdy, "R1 R2 accept readiness", int'(inReady), int'(eRdy));
    check(readGrant === eRd, "R4 R5 read grant", int'(readGrant), int'(eRd));
    check(writeGrant === eWv, "R6 R7 R8 write grant", int'(writeGrant), int'(eWv));
    if (eW >= 0) check(writeReg === RW'(mFi[eW]), "R8 write register", int'(writeReg), mFi[eW]);
    for (int u = 0; u < NU; u++) begin
      if (readGrant[u]) lastRead[u] = cycleNo;
      if (writeGrant[u]) lastWrite[u] = cycleNo;
    end
    // done pulses, judged on state before this edge
    for (int u = 0; u < NU; u++)
      if (doneIn[u] && mBusy[u] && mRdDone[u] && u != eW) mExDone[u] = 1;
    if (eW >= 0) begin
      mBusy[eW] = 0; mExDone[eW] = 0; pPend[mFi[eW]] = 0;
      for (int u = 0; u < NU; u++) begin
        if (mQjP[u] && mQj[u] == eW) begin mQjP[u] = 0; mRj[u] = 1; end
        if (mQkP[u] && mQk[u] == eW) begin mQkP[u] = 0; mRk[u] = 1; end
      end
    end
    for (int u = 0; u < NU; u++) begin
      if (eRd[u]) begin
        mRdDone[u] = 1; mRj[u] = 0; mRk[u] = 0; cnt[u] = lat[u];
      end else if (cnt[u] > 0) cnt[u]--;
    end
    acc = v && eRdy;
    if (acc) begin
      mBusy[un] = 1; mRdDone[un] = 0; mExDone[un] = 0;
      mFi[un] = d; mFj[un] = a; mFk[un] = b;
      mQjP[un] = pPend[a]; mQj[un] = pUnit[a]; mRj[un] = !pPend[a];
      mQkP[un] = pPend[b]; mQk[un] = pUnit[b]; mRk[un] = !pPend[b];
      pPend[d] = 1; pUnit[d] = un;
    end
    cycleNo++;
  endtask

  task automatic issue(input int un, input int d, input int a, input int b, output int accCycle);
    bit acc = 0;
    while (!acc) tick(1, un, d, a, b, acc);
    accCycle = cycleNo - 1;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, acc);
  endtask

  task automatic doReset();
    rst = 1; inValid = 0; doneIn = '0; forceDone = '0;
    inUnit = '0; inDst = '0; inSrcA = '0; inSrcB = '0;
    repeat (3) @(negedge clk);
    modelReset();
    @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycleNo, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1, c2, wBefore[NU];
    bit hold, rv, acc;
    int ru, rd, ra, rb;
    void'($urandom(32'd20240611));
    lat[0] = 3; lat[1] = 2; lat[2] = 2; lat[3] = 20;
    doReset();

    // R3: idle after reset
    for (int u = 0; u < NU; u++) begin
      inUnit = UW'(u); inDst = RW'(2 * u);
      #1;
      check(inReady === 1'b1, "R3 ready after reset", int'(inReady), 1);
      check(readGrant === '0 && writeGrant === '0, "R3 no grants after reset",
            int'(readGrant | writeGrant), 0);
    end

    // R5/R7: long divide feeds add; multiply overwrites a register add still reads
    issue(3, 0, 2, 3, c0);
    issue(2, 5, 0, 6, c0);
    issue(1, 6, 1, 1, c0);
    idle(40);
    check(lastRead[2] == lastWrite[3] + 1, "R5 consumer read after producer write", lastRead[2], lastWrite[3] + 1);
    check(lastWrite[1] == lastRead[2] + 1, "R7 held write follows reader", lastWrite[1], lastRead[2] + 1);

    // R8: integer and add finish together; integer wins
    issue(0, 1, 2, 2, c0);
    issue(2, 3, 4, 4, c0);
    idle(12);
    check(lastWrite[2] == lastWrite[0] + 1, "R8 priority on tie", lastWrite[2], lastWrite[0] + 1);

    // R2/R9: same destination waits for the writer
    issue(1, 7, 1, 2, c0);
    issue(0, 7, 3, 3, c1);
    check(c1 == lastWrite[1] + 1, "R2 R9 WAW release", c1, lastWrite[1] + 1);
    // R1: same unit waits for the unit to free
    issue(2, 4, 0, 0, c0);
    issue(2, 2, 0, 0, c2);
    check(c2 == lastWrite[2] + 1, "R1 structural release", c2, lastWrite[2] + 1);
    idle(20);

    // R6: stray done pulses on idle units
    for (int u = 0; u < NU; u++) wBefore[u] = lastWrite[u];
    forceDone = '1;
    idle(1);
    forceDone = '0;
    idle(4);
    for (int u = 0; u < NU; u++)
      check(lastWrite[u] == wBefore[u], "R6 stray done ignored", lastWrite[u], wBefore[u]);

    // Random traffic
    for (int u = 0; u < NU; u++) lat[u] = 1 + int'($urandom % 6);
    hold = 0; rv = 0; ru = 0; rd = 0; ra = 0; rb = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!hold) begin
        rv = ($urandom % 4) != 0;
        ru = int'($urandom % NU); rd = int'($urandom % NR);
        ra = int'($urandom % NR); rb = int'($urandom % NR);
      end
      for (int u = 0; u < NU; u++)
        forceDone[u] = (($urandom % 8) == 0) && (!mBusy[u] || !mRdDone[u]);
      tick(rv, ru, rd, ra, rb, acc);
      hold = rv && !acc;
      if (i % 1000 == 999) for (int u = 0; u < NU; u++) lat[u] = 1 + int'($urandom % 6);
    end
    forceDone = '0;
    idle(150);
    for (int u = 0; u < NU; u++)
      check(!mBusy[u], "R9 all units drained", int'(mBusy[u]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule